// File: doc/BRIEF.md
# PCIe Link Health Monitor with Receiver-Lock Recovery

This block decides, on request, whether a PCIe link can be used. It looks at two debug status words exported by the link controller: the second word carries a link-up flag and a training-active flag, the first carries the current link training state machine (LTSSM) state in its low bits. A link that is up and no longer training is reported good at once. A link that is up but still training is looked at again after a wait. A link that is down, or that never leaves training, goes to a stall check.

The stall check targets one known failure: a speed change to the second generation rate that hangs in the receiver-lock recovery state while the PHY receiver reports no valid data. The block reads the PHY's receive status register through an indirect register port: a request/acknowledge interface to a separate handshake engine that turns each request into the PHY's own access sequence. If the stall is confirmed, the block forces the receiver data and PLL enable overrides on in the PHY's receive override register, keeps them on for a set number of cycles, then clears them. Each check ends with a one-cycle done pulse and three held result flags.

Top module: `link_health_mon`

## Requirements
- R1: After reset, `chk_done`, `link_good`, `recovered`, `recov_error` and `phy_req` are all 0.
- R2: When a check starts with bit 4 (link up) of `dbg_stat1` set and bit 29 (training active) clear, the check ends within 3 cycles with `link_good`=1, `recovered`=0 and no PHY access.
- R3: While link up and training active are both set, the flags are sampled again every `RETRY_CYC` cycles; if training clears before the retries run out, the check ends with `link_good`=1 and no PHY access.
- R4: If training stays active, the flags are sampled `MAX_RETRY`+1 times in all, separated by `MAX_RETRY` waits, before the first PHY access is issued.
- R5: If link up is clear at the first sample, the first PHY access is issued within 4 cycles of the start, with no retry wait.
- R6: The first PHY access is a read (`phy_we`=0) of address 0x100D; if bit 0 of the returned data (receive valid) is 1, the check ends with `link_good`=0, `recovered`=0 and no further access.
- R7: If receive valid is 0 but the low 6 bits of `dbg_stat0` are not 0x0D, the check ends with `recovered`=0 and no write; higher bits of `dbg_stat0` are not compared.
- R8: If receive valid is 0 and the low 6 bits of `dbg_stat0` equal 0x0D, the block reads 0x1005, writes it back with bits 5 and 3 set, reads 0x1005 again, writes it back with bits 5 and 3 clear (other bits kept from each read), then ends with `recovered`=1 and `link_good`=0.
- R9: At least `HOLD_CYC` cycles pass between the acknowledge of the set write and the request of the second read of 0x1005.
- R10: If `phy_err` is 1 with any `phy_ack`, the block issues no further access and ends the check with `recov_error`=1, `recovered`=0, `link_good`=0.
- R11: A request holds `phy_req`, `phy_we`, `phy_addr` and `phy_wdata` steady until acknowledged; the result flags hold their values until the next check ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chk_start | input | 1 | Start a check; ignored while one is running |
| dbg_stat0 | input | DBG_W | Debug word holding the LTSSM state in its low bits |
| dbg_stat1 | input | DBG_W | Debug word holding the link-up and training flags |
| phy_req | output | 1 | PHY register access request |
| phy_we | output | 1 | 1 = write, 0 = read |
| phy_addr | output | PHY_AW | PHY register address |
| phy_wdata | output | PHY_DW | Write data |
| phy_ack | input | 1 | One-cycle acknowledge of the current access |
| phy_rdata | input | PHY_DW | Read data, valid with `phy_ack` |
| phy_err | input | 1 | Access failed, valid with `phy_ack` |
| chk_done | output | 1 | One-cycle pulse when a check ends |
| link_good | output | 1 | Last check found the link up and trained |
| recovered | output | 1 | Last check ran the receiver override pulse |
| recov_error | output | 1 | Last check was aborted by a PHY access error |

## Verification
A wrong retry count or a wrong wait length moves the first PHY request in time, so the bench times that request against the start pulse rather than only reading the final flags. A wrongly decoded state or receive-valid bit shows up on the very next access as a write that should not exist, or a missing one, and the written data exposes any mask error in the same cycle the write is acknowledged. A hold timer that expires early shows as a second read of the override register arriving too soon after the set write; an error that does not abort shows as extra accesses after the failing acknowledge.

// File: rtl/lkm_pkg.sv
package lkm_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_EVAL,
      ST_WAIT,
      ST_RXV,
      ST_RD_SET,
      ST_WR_SET,
      ST_HOLD,
      ST_RD_CLR,
      ST_WR_CLR
   } lkm_state_e;

endpackage

// File: rtl/lkm_decode.sv
module lkm_decode #(
   parameter int DBG_W       = 32,
   parameter int PHY_DW      = 16,
   parameter int UP_BIT      = 4,
   parameter int TRAIN_BIT   = 29,
   parameter int STATE_W     = 6,
   parameter int LOCK_STATE  = 13,
   parameter int RXV_BIT     = 0
) (
   input  logic [DBG_W-1:0]  dbg0,
   input  logic [DBG_W-1:0]  dbg1,
   input  logic [PHY_DW-1:0] rdata,
   output logic              link_up,
   output logic              training,
   output logic              in_lock,
   output logic              rx_valid
);

   if (UP_BIT >= DBG_W || TRAIN_BIT >= DBG_W) begin : g_bad_flag_pos
      $error("flag bit outside debug word");
   end
   if (STATE_W > DBG_W || LOCK_STATE >= (1 << STATE_W)) begin : g_bad_state
      $error("state field does not fit");
   end
   if (RXV_BIT >= PHY_DW) begin : g_bad_rxv
      $error("receive-valid bit outside PHY word");
   end

   assign link_up  = dbg1[UP_BIT];
   assign training = dbg1[TRAIN_BIT];
   assign in_lock  = (dbg0[STATE_W-1:0] == STATE_W'(LOCK_STATE));
   assign rx_valid = rdata[RXV_BIT];

   logic unused_bits;
   assign unused_bits = ^{dbg0, dbg1, rdata};

endmodule

// File: rtl/lkm_timer.sv
module lkm_timer #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] len,
   output logic          expired
);

   logic [CW-1:0] cnt_q;
   logic          run_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         run_q <= 1'b0;
      end else if (load) begin
         cnt_q <= len - CW'(1);
         run_q <= 1'b1;
      end else if (run_q) begin
         if (cnt_q == '0) run_q <= 1'b0;
         else             cnt_q <= cnt_q - CW'(1);
      end
   end

   assign expired = run_q && (cnt_q == '0);

   // R9
   tmr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      expired |=> !expired || load);

endmodule

// File: rtl/link_health_mon.sv
module link_health_mon
   import lkm_pkg::*;
#(
   parameter int DBG_W      = 32,
   parameter int PHY_AW     = 16,
   parameter int PHY_DW     = 16,
   parameter int MAX_RETRY  = 5,
   parameter int RETRY_CYC  = 1000,
   parameter int HOLD_CYC   = 250000,
   parameter int RXV_ADDR   = 'h100D,
   parameter int OVR_ADDR   = 'h1005,
   parameter int OVR_MASK   = 'h0028
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              chk_start,
   input  logic [DBG_W-1:0]  dbg_stat0,
   input  logic [DBG_W-1:0]  dbg_stat1,
   output logic              phy_req,
   output logic              phy_we,
   output logic [PHY_AW-1:0] phy_addr,
   output logic [PHY_DW-1:0] phy_wdata,
   input  logic              phy_ack,
   input  logic [PHY_DW-1:0] phy_rdata,
   input  logic              phy_err,
   output logic              chk_done,
   output logic              link_good,
   output logic              recovered,
   output logic              recov_error
);

   localparam int MAXC = (RETRY_CYC > HOLD_CYC) ? RETRY_CYC : HOLD_CYC;
   localparam int CW   = $clog2(MAXC + 1);
   localparam int RW   = $clog2(MAX_RETRY + 1);

   if (RETRY_CYC < 1 || HOLD_CYC < 1) begin : g_bad_len
      $error("wait lengths must be at least one cycle");
   end
   if (MAX_RETRY < 1) begin : g_bad_retry
      $error("MAX_RETRY must be at least one");
   end

   lkm_state_e     st_q, st_d;
   logic [RW-1:0]  retry_q;
   logic [PHY_DW-1:0] ovr_q;
   logic           up, trn, lock, rxv, expired;
   logic           tmr_load;
   logic [CW-1:0]  tmr_len;
   logic           fin, fin_good, fin_rec, fin_err;
   logic           ok_ack, bad_ack;

   lkm_decode #(
      .DBG_W(DBG_W), .PHY_DW(PHY_DW)
   ) u_dec (
      .dbg0(dbg_stat0), .dbg1(dbg_stat1), .rdata(phy_rdata),
      .link_up(up), .training(trn), .in_lock(lock), .rx_valid(rxv)
   );

   lkm_timer #(.CW(CW)) u_tmr (
      .clk(clk), .rst_n(rst_n), .load(tmr_load), .len(tmr_len), .expired(expired)
   );

   assign ok_ack  = phy_ack && !phy_err;
   assign bad_ack = phy_ack && phy_err;

   always_comb begin
      st_d     = st_q;
      fin      = 1'b0;
      fin_good = 1'b0;
      fin_rec  = 1'b0;
      fin_err  = 1'b0;
      tmr_load = 1'b0;
      tmr_len  = CW'(HOLD_CYC);
      unique case (st_q)
         ST_IDLE:   if (chk_start) st_d = ST_EVAL;
         ST_EVAL: begin
            if (!up)                                 st_d = ST_RXV;
            else if (!trn)                           begin fin = 1'b1; fin_good = 1'b1; end
            else if (retry_q == RW'(MAX_RETRY))      st_d = ST_RXV;
            else begin
               st_d     = ST_WAIT;
               tmr_load = 1'b1;
               tmr_len  = CW'(RETRY_CYC);
            end
         end
         ST_WAIT:   if (expired) st_d = ST_EVAL;
         ST_RXV: begin
            if (bad_ack)                       begin fin = 1'b1; fin_err = 1'b1; end
            else if (ok_ack && (rxv || !lock)) fin = 1'b1;
            else if (ok_ack)                   st_d = ST_RD_SET;
         end
         ST_RD_SET: begin
            if (bad_ack)     begin fin = 1'b1; fin_err = 1'b1; end
            else if (ok_ack) st_d = ST_WR_SET;
         end
         ST_WR_SET: begin
            if (bad_ack)     begin fin = 1'b1; fin_err = 1'b1; end
            else if (ok_ack) begin st_d = ST_HOLD; tmr_load = 1'b1; end
         end
         ST_HOLD:   if (expired) st_d = ST_RD_CLR;
         ST_RD_CLR: begin
            if (bad_ack)     begin fin = 1'b1; fin_err = 1'b1; end
            else if (ok_ack) st_d = ST_WR_CLR;
         end
         ST_WR_CLR: begin
            if (bad_ack)     begin fin = 1'b1; fin_err = 1'b1; end
            else if (ok_ack) begin fin = 1'b1; fin_rec = 1'b1; end
         end
         default:   st_d = ST_IDLE;
      endcase
      if (fin) st_d = ST_IDLE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q        <= ST_IDLE;
         retry_q     <= '0;
         ovr_q       <= '0;
         chk_done    <= 1'b0;
         link_good   <= 1'b0;
         recovered   <= 1'b0;
         recov_error <= 1'b0;
      end else begin
         st_q     <= st_d;
         chk_done <= fin;
         if (fin) begin
            link_good   <= fin_good;
            recovered   <= fin_rec;
            recov_error <= fin_err;
         end
         if (st_q == ST_IDLE)                      retry_q <= '0;
         else if (st_q == ST_EVAL && tmr_load)     retry_q <= retry_q + RW'(1);
         if (ok_ack && st_q == ST_RD_SET)          ovr_q <= phy_rdata | PHY_DW'(OVR_MASK);
         if (ok_ack && st_q == ST_RD_CLR)          ovr_q <= phy_rdata & ~PHY_DW'(OVR_MASK);
      end
   end

   always_comb begin
      phy_req   = 1'b0;
      phy_we    = 1'b0;
      phy_addr  = PHY_AW'(OVR_ADDR);
      phy_wdata = ovr_q;
      unique case (st_q)
         ST_RXV:               begin phy_req = 1'b1; phy_addr = PHY_AW'(RXV_ADDR); end
         ST_RD_SET, ST_RD_CLR: phy_req = 1'b1;
         ST_WR_SET, ST_WR_CLR: begin phy_req = 1'b1; phy_we = 1'b1; end
         default:              phy_req = 1'b0;
      endcase
   end

   // hold-window observer for R9
   logic          armed_q;
   logic [CW-1:0] since_q;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         since_q <= '0;
      end else begin
         if (phy_ack && phy_we && phy_wdata[3] && phy_wdata[5] && !armed_q) begin
            armed_q <= 1'b1;
            since_q <= '0;
         end else if (armed_q && phy_req && !phy_we) begin
            armed_q <= 1'b0;
         end else if (armed_q && since_q != {CW{1'b1}}) begin
            since_q <= since_q + CW'(1);
         end
      end
   end

   // R9
   hold_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed_q && phy_req && !phy_we) |-> (since_q >= CW'(HOLD_CYC - 1)));

   // R11
   req_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phy_req && !phy_ack) |=> (phy_req && $stable(phy_addr) && $stable(phy_we) && $stable(phy_wdata)));

   // R2
   good_noacc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_done && link_good) |-> (!recovered && !recov_error && !phy_req));

   // R10
   err_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phy_ack && phy_err) |=> !phy_req);

   // R11
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chk_done |=> !chk_done);

endmodule

// File: tb/sim_link_health_mon.sv
`timescale 1ns/1ps
module sim_link_health_mon;

   localparam int RETRY = 20;
   localparam int HOLD  = 50;
   localparam int MAXR  = 5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        chk_start = 1'b0;
   logic [31:0] dbg_stat0 = '0;
   logic [31:0] dbg_stat1 = '0;
   logic        phy_req, phy_we;
   logic [15:0] phy_addr, phy_wdata;
   logic        phy_ack = 1'b0;
   logic [15:0] phy_rdata = '0;
   logic        phy_err = 1'b0;
   logic        chk_done, link_good, recovered, recov_error;

   always #4 clk = ~clk;

   link_health_mon #(
      .MAX_RETRY(MAXR), .RETRY_CYC(RETRY), .HOLD_CYC(HOLD)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .chk_start(chk_start),
      .dbg_stat0(dbg_stat0), .dbg_stat1(dbg_stat1),
      .phy_req(phy_req), .phy_we(phy_we), .phy_addr(phy_addr), .phy_wdata(phy_wdata),
      .phy_ack(phy_ack), .phy_rdata(phy_rdata), .phy_err(phy_err),
      .chk_done(chk_done), .link_good(link_good), .recovered(recovered),
      .recov_error(recov_error)
   );

   // PHY register model and access log
   logic [15:0] rxv_reg = '0;
   logic [15:0] ovr_reg = '0;
   int          err_target = -1;
   int          cyc = 0;
   int          n_acc = 0;
   logic        in_acc = 1'b0;
   int          rise_cyc [64];
   int          ack_cyc  [64];
   logic [15:0] log_addr [64];
   logic        log_we   [64];
   logic [15:0] log_wd   [64];

   always @(posedge clk) begin
      cyc     <= cyc + 1;
      phy_ack <= 1'b0;
      phy_err <= 1'b0;
      if (phy_req && !phy_ack) begin
         phy_ack   <= 1'b1;
         phy_err   <= (n_acc == err_target);
         phy_rdata <= (phy_addr == 16'h100D) ? rxv_reg : ovr_reg;
         if (phy_we && n_acc != err_target && phy_addr == 16'h1005) ovr_reg <= phy_wdata;
      end
      if (phy_req && !in_acc && !phy_ack) begin
         rise_cyc[n_acc % 64] <= cyc;
         in_acc <= 1'b1;
      end
      if (phy_ack) begin
         ack_cyc[n_acc % 64]  <= cyc;
         log_addr[n_acc % 64] <= phy_addr;
         log_we[n_acc % 64]   <= phy_we;
         log_wd[n_acc % 64]   <= phy_wdata;
         n_acc  <= n_acc + 1;
         in_acc <= 1'b0;
      end
   end

   int checks = 0;
   int fails  = 0;
   logic summary_done = 1'b0;

   task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   int base, t_start, done_cyc;

   task automatic run_check(output logic timed_out);
      @(negedge clk);
      base      = n_acc;
      t_start   = cyc;
      chk_start = 1'b1;
      @(negedge clk);
      chk_start = 1'b0;
      timed_out = 1'b1;
      for (int i = 0; i < 2000; i++) begin
         if (chk_done) begin timed_out = 1'b0; break; end
         @(negedge clk);
      end
      done_cyc = cyc;
      @(negedge clk);
   endtask

   task automatic t_reset;
      chk(!chk_done && !link_good && !recovered && !recov_error && !phy_req, "R1 reset outputs",
          {chk_done, link_good, recovered, recov_error, phy_req}, 0);
   endtask

   task automatic t_good;
      logic to;
      dbg_stat1 = 32'h0000_0010;
      dbg_stat0 = 32'h0;
      run_check(to);
      chk(!to && link_good && !recovered && !recov_error, "R2 good link flags",
          {to, link_good, recovered, recov_error}, 4'b0100);
      chk(n_acc == base, "R2 no PHY access", n_acc - base, 0);
      chk(done_cyc - t_start <= 3, "R2 latency", done_cyc - t_start, 3);
   endtask

   task automatic t_train_clears;
      logic to;
      dbg_stat1 = 32'h2000_0010;
      @(negedge clk);
      base      = n_acc;
      t_start   = cyc;
      chk_start = 1'b1;
      @(negedge clk);
      chk_start = 1'b0;
      repeat (2 * RETRY + 5) @(negedge clk);
      chk(!chk_done && !phy_req, "R3 still waiting", {chk_done, phy_req}, 0);
      dbg_stat1 = 32'h0000_0010;
      to = 1'b1;
      for (int i = 0; i < 500; i++) begin
         if (chk_done) begin to = 1'b0; break; end
         @(negedge clk);
      end
      @(negedge clk);
      chk(!to && link_good, "R3 good after training ends", link_good, 1);
      chk(n_acc == base, "R3 no PHY access", n_acc - base, 0);
   endtask

   task automatic t_train_stuck;
      logic to;
      int gap;
      dbg_stat1 = 32'h2000_0010;
      rxv_reg   = 16'h0001;
      run_check(to);
      gap = rise_cyc[base % 64] - t_start;
      chk(!to && gap >= MAXR * RETRY && gap <= MAXR * (RETRY + 3) + 6,
          "R4 retries before PHY access", gap, MAXR * RETRY);
      chk(log_addr[base % 64] == 16'h100D && !log_we[base % 64], "R4 first access reads 100D",
          log_addr[base % 64], 16'h100D);
      chk(!link_good && !recovered, "R4 not good", {link_good, recovered}, 0);
   endtask

   task automatic t_down_fast;
      logic to;
      int gap;
      dbg_stat1 = 32'h2000_0000;
      dbg_stat0 = 32'h0000_000D;
      rxv_reg   = 16'hFFF1;
      run_check(to);
      gap = rise_cyc[base % 64] - t_start;
      chk(!to && gap <= 4, "R5 no retry when down", gap, 4);
      chk(n_acc - base == 1 && !log_we[base % 64], "R6 one read only", n_acc - base, 1);
      chk(!link_good && !recovered && !recov_error, "R6 rx valid result",
          {link_good, recovered, recov_error}, 0);
   endtask

   task automatic t_not_lock;
      logic to;
      dbg_stat1 = 32'h0;
      dbg_stat0 = 32'hFFFF_FFCC;
      rxv_reg   = 16'hFFFE;
      run_check(to);
      chk(!to && n_acc - base == 1, "R7 no write off-state", n_acc - base, 1);
      chk(!recovered && !link_good, "R7 flags", {recovered, link_good}, 0);
   endtask

   task automatic t_recover(input logic [15:0] init, input logic [31:0] st0);
      logic to;
      int hold_gap;
      dbg_stat1 = 32'h0;
      dbg_stat0 = st0;
      rxv_reg   = 16'h0000;
      ovr_reg   = init;
      run_check(to);
      chk(!to && n_acc - base == 5, "R8 five accesses", n_acc - base, 5);
      chk(log_we[(base+2) % 64] && log_addr[(base+2) % 64] == 16'h1005 &&
          log_wd[(base+2) % 64] == (init | 16'h0028), "R8 set write data",
          log_wd[(base+2) % 64], init | 16'h0028);
      chk(log_we[(base+4) % 64] && log_wd[(base+4) % 64] == (init & ~16'h0028),
          "R8 clear write data", log_wd[(base+4) % 64], init & ~16'h0028);
      chk(recovered && !link_good && !recov_error, "R8 result flags",
          {recovered, link_good, recov_error}, 3'b100);
      hold_gap = rise_cyc[(base+3) % 64] - ack_cyc[(base+2) % 64];
      chk(hold_gap >= HOLD && hold_gap <= HOLD + 4, "R9 hold length", hold_gap, HOLD);
   endtask

   task automatic t_error;
      logic to;
      dbg_stat1  = 32'h0;
      dbg_stat0  = 32'h0000_000D;
      rxv_reg    = 16'h0000;
      ovr_reg    = 16'h1234;
      err_target = n_acc + 2;
      run_check(to);
      repeat (5) @(negedge clk);
      chk(!to && n_acc - base == 3, "R10 stop after error", n_acc - base, 3);
      chk(recov_error && !recovered && !link_good, "R10 error flags",
          {recov_error, recovered, link_good}, 3'b100);
      err_target = -1;
   endtask

   task automatic t_hold_result;
      repeat (10) @(negedge clk);
      chk(recov_error && !chk_done, "R11 flags held between checks", recov_error, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_good();
      t_train_clears();
      t_train_stuck();
      t_down_fast();
      t_not_lock();
      t_recover(16'h8104, 32'h0000_00CD);
      t_recover(16'h00FF, 32'h0000_004D);
      t_error();
      t_hold_result();
      t_good();
      chk(!recov_error, "R10 error cleared by next check", recov_error, 0);
      if (!summary_done) begin
         summary_done = 1'b1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!summary_done) begin
         summary_done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=0x0 expected=0x1");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule